// File: doc/BRIEF.md
# Byte-Framed Serial ADC Read Controller

This block is an SPI master that fetches one 12-bit conversion result from a serial analog-to-digital converter. The whole exchange uses three 8-bit transfers, 24 SCLK cycles in total. The command is padded with zeros ahead of its start bit. That padding puts the result in fixed places: the low nibble of the second received byte and all of the third received byte. A host asks for a conversion with a single-cycle start strobe. With the same strobe it gives the channel selection bits and the clock polarity. It gets back a 12-bit value together with a one-cycle completion pulse.

SCLK is made from the system clock. Each SCLK level lasts `HALF_DIV` system cycles. MOSI changes only while SCLK is low, and MISO is captured at every rising SCLK edge. Two clock conventions are available. In the first, SCLK rests low between frames. In the second, SCLK rests high between frames. In both, data changes on the falling edge and is sampled on the rising edge. All pin outputs come straight from flip-flops. Between two frames, chip select stays high for at least one full SCLK period.

Top module: `adc_byte_spi_rd`

## Requirements
- R1: A frame holds `cs_n_o` low for exactly 24 rising SCLK edges. `cs_n_o` returns high after the 24th high level.
- R2: The MOSI bits seen at rising edges 1 to 8 are `0000_0001`, sent MSB first. The single 1 is the start bit.
- R3: MOSI at rising edges 9, 10 and 11 carries `single_end_i`, `chan_odd_i` and `msb_first_i`, as captured with the accepted start. MOSI at edges 12 to 24 is 0.
- R4: During a frame, MOSI changes only while SCLK is low. It holds steady through every SCLK high level.
- R5: While idle, `sclk_o` follows `idle_high_i` one cycle later: 0 means it rests low, 1 means it rests high. When a frame ends, SCLK goes back to the polarity captured with the start.
- R6: MISO is sampled at each rising edge. `result_o` is the bits from edges 13 to 24, MSB first. The bits at edges 1 to 12, which include the null bit, do not affect the result.
- R7: `done_o` is high for exactly one cycle, the same cycle in which `cs_n_o` rises. `result_o` keeps its value until the next `done_o`.
- R8: `busy_o` rises in the cycle after an accepted start and stays high through the inter-frame gap. A start while `busy_o` is high is ignored, and so are the inputs given with it.
- R9: Between consecutive frames, `cs_n_o` stays high for at least 2*`HALF_DIV` system cycles.
- R10: Inside a frame, every SCLK low level and every SCLK high level lasts exactly `HALF_DIV` system cycles.
- R11: While reset is held, `cs_n_o`=1, `sclk_o`=0, `mosi_o`=0, `busy_o`=0, `done_o`=0 and `result_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Requests one conversion read when idle |
| single_end_i | input | 1 | Single-ended (1) or differential (0) input select, sent as command bit |
| chan_odd_i | input | 1 | Channel / polarity select bit, sent as command bit |
| msb_first_i | input | 1 | Output-order select bit, sent as command bit |
| idle_high_i | input | 1 | SCLK rest level: 0 = low, 1 = high |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the converter |
| busy_o | output | 1 | Frame or inter-frame gap in progress |
| done_o | output | 1 | One-cycle pulse when `result_o` is new |
| result_o | output | 12 | Last conversion result |

## Verification
The bench builds the block with `HALF_DIV` = 3. Because this is odd and larger than one, it exposes off-by-one errors in the divider count and in the gap length, and each frame stays short enough for dozens of randomised reads. The converter model in the bench puts random junk on MISO before the null bit. That shows whether the 12 result bits are taken from the right frame positions in both clock polarities. Start pulses are also sent in the middle of a frame and inside the gap, to exercise the guard against starts while busy.

// File: rtl/adc_spi_pkg.sv
package adc_spi_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FRAME = 2'd1,
      ST_GAP   = 2'd2
   } adc_state_e;

   // Command bits that follow the start bit, in transmit order.
   typedef struct packed {
      logic single_end;
      logic chan_odd;
      logic msb_first;
   } adc_cfg_t;

endpackage

// File: rtl/adc_spi_tick.sv
// Half-period divider: pulses once every HALF_DIV cycles while run_i is high.
module adc_spi_tick #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic tick_o
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] cnt_q;

   assign tick_o = run_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i || tick_o) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assert_tick_range_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/adc_spi_shift.sv
// Bit engine: walks the frame in half periods, shifts MOSI on falls, samples MISO on rises.
module adc_spi_shift #(
   parameter int FRAME_BITS = 24,
   parameter int RES_W      = 12
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load_i,
   input  logic [FRAME_BITS-1:0] cmd_i,
   input  logic                  tick_i,
   input  logic                  active_i,
   input  logic                  miso_i,
   output logic                  mosi_o,
   output logic                  rise_o,
   output logic                  fall_o,
   output logic                  last_o,
   output logic [RES_W-1:0]      rx_o
);
   localparam int BW = $clog2(FRAME_BITS);
   localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_BITS - 1);

   logic                  half_q;
   logic [BW-1:0]         bit_q;
   logic [FRAME_BITS-1:0] tx_q;
   logic [RES_W-1:0]      rx_q;
   logic                  mosi_q;

   assign rise_o = active_i && tick_i && !half_q;
   assign fall_o = active_i && tick_i &&  half_q;
   assign last_o = fall_o && (bit_q == LAST_BIT);
   assign mosi_o = mosi_q;
   assign rx_o   = rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         half_q <= 1'b0;
         bit_q  <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
         mosi_q <= 1'b0;
      end else if (load_i) begin
         half_q <= 1'b0;
         bit_q  <= '0;
         mosi_q <= cmd_i[FRAME_BITS-1];
         tx_q   <= {cmd_i[FRAME_BITS-2:0], 1'b0};
      end else if (rise_o) begin
         half_q <= 1'b1;
         rx_q   <= {rx_q[RES_W-2:0], miso_i};
      end else if (fall_o) begin
         half_q <= 1'b0;
         if (last_o) begin
            mosi_q <= 1'b0;
         end else begin
            mosi_q <= tx_q[FRAME_BITS-1];
            tx_q   <= {tx_q[FRAME_BITS-2:0], 1'b0};
            bit_q  <= bit_q + 1'b1;
         end
      end
   end

   // R4: the transmit bit never moves during a high half period
   assert_mosi_hold_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (rise_o && !load_i) |=> $stable(mosi_o));

endmodule

// File: rtl/adc_byte_spi_rd.sv
module adc_byte_spi_rd #(
   parameter int HALF_DIV = 4,
   parameter int BYTE_W   = 8,
   parameter int N_BYTES  = 3,
   parameter int RES_W    = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             single_end_i,
   input  logic             chan_odd_i,
   input  logic             msb_first_i,
   input  logic             idle_high_i,
   input  logic             miso_i,
   output logic             cs_n_o,
   output logic             sclk_o,
   output logic             mosi_o,
   output logic             busy_o,
   output logic             done_o,
   output logic [RES_W-1:0] result_o
);
   import adc_spi_pkg::*;

   localparam int FRAME_BITS = BYTE_W * N_BYTES;
   localparam int CFG_W      = $bits(adc_cfg_t);
   localparam int START_POS  = FRAME_BITS - BYTE_W;
   localparam int GAP_MIN    = 2 * HALF_DIV;
   localparam int EW         = $clog2(FRAME_BITS + 1);
   localparam int GW         = $clog2(GAP_MIN + 1);

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (N_BYTES < 2) begin : g_bad_bytes
         $error("frame needs at least two bytes");
      end
      if (RES_W + 1 > FRAME_BITS - BYTE_W - CFG_W) begin : g_bad_res
         $error("result and null bit overlap the command");
      end
   endgenerate

   adc_state_e             state_q;
   logic                   cs_q, sclk_q, busy_q, done_q, cpol_q, gap_q;
   logic [RES_W-1:0]       res_q;
   logic [FRAME_BITS-1:0]  cmd;
   adc_cfg_t               cfg;
   logic                   accept, tick, rise, fall, last;
   logic [RES_W-1:0]       rx;

   assign cfg    = '{single_end: single_end_i, chan_odd: chan_odd_i, msb_first: msb_first_i};
   assign accept = (state_q == ST_IDLE) && start_i;

   always_comb begin
      cmd                               = '0;
      cmd[START_POS]                    = 1'b1;
      cmd[START_POS-1 -: CFG_W]         = cfg;
   end

   adc_spi_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (state_q != ST_IDLE),
      .tick_o (tick)
   );

   adc_spi_shift #(.FRAME_BITS(FRAME_BITS), .RES_W(RES_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (accept),
      .cmd_i    (cmd),
      .tick_i   (tick),
      .active_i (state_q == ST_FRAME),
      .miso_i   (miso_i),
      .mosi_o   (mosi_o),
      .rise_o   (rise),
      .fall_o   (fall),
      .last_o   (last),
      .rx_o     (rx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cs_q    <= 1'b1;
         sclk_q  <= 1'b0;
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         cpol_q  <= 1'b0;
         gap_q   <= 1'b0;
         res_q   <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               sclk_q <= idle_high_i;
               if (start_i) begin
                  state_q <= ST_FRAME;
                  cs_q    <= 1'b0;
                  sclk_q  <= 1'b0;
                  busy_q  <= 1'b1;
                  cpol_q  <= idle_high_i;
               end
            end
            ST_FRAME: begin
               if (rise) begin
                  sclk_q <= 1'b1;
               end else if (last) begin
                  state_q <= ST_GAP;
                  cs_q    <= 1'b1;
                  sclk_q  <= cpol_q;
                  done_q  <= 1'b1;
                  res_q   <= rx;
                  gap_q   <= 1'b0;
               end else if (fall) begin
                  sclk_q <= 1'b0;
               end
            end
            ST_GAP: begin
               if (tick) begin
                  if (gap_q) begin
                     state_q <= ST_IDLE;
                     busy_q  <= 1'b0;
                  end else begin
                     gap_q <= 1'b1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cs_n_o   = cs_q;
   assign sclk_o   = sclk_q;
   assign busy_o   = busy_q;
   assign done_o   = done_q;
   assign result_o = res_q;

   // ---------------- checker state ----------------
   logic          sclk_d, armed_q;
   logic [EW-1:0] edge_cnt;
   logic [GW-1:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         armed_q  <= 1'b0;
         edge_cnt <= '0;
         hi_cnt   <= GW'(GAP_MIN);
      end else begin
         sclk_d  <= sclk_o;
         armed_q <= 1'b1;
         if (cs_n_o) edge_cnt <= '0;
         else if (sclk_o && !sclk_d) edge_cnt <= edge_cnt + 1'b1;
         if (!cs_n_o) hi_cnt <= '0;
         else if (hi_cnt < GW'(GAP_MIN)) hi_cnt <= hi_cnt + 1'b1;
      end
   end

   assert_edge_count_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> (edge_cnt == EW'(FRAME_BITS)));

   assert_mosi_steady_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_o && sclk_o && $past(!cs_n_o && sclk_o)) |-> $stable(mosi_o));

   assert_idle_level_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && !busy_o && $past(!busy_o)) |-> (sclk_o == $past(idle_high_i)));

   assert_done_pulse_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_cs_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (cs_n_o && $past(!cs_n_o)));

   assert_ignore_start_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> !$fell(cs_n_o));

   assert_gap_len_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n_o) |-> (hi_cnt >= GW'(GAP_MIN)));

endmodule

// File: tb/sim_adc_byte_spi_rd.sv
module sim_adc_byte_spi_rd;
   localparam int H = 3;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic se = 1'b0, od = 1'b0, mf = 1'b0, ih = 1'b0, miso = 1'b0;
   logic cs_n, sclk, mosi, busy, done;
   logic [11:0] result;

   always #2.5 clk = ~clk;

   adc_byte_spi_rd #(.HALF_DIV(H)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .single_end_i(se),
      .chan_odd_i(od), .msb_first_i(mf), .idle_high_i(ih), .miso_i(miso),
      .cs_n_o(cs_n), .sclk_o(sclk), .mosi_o(mosi), .busy_o(busy),
      .done_o(done), .result_o(result));

   int tests = 0, fails = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // converter model and pin monitor
   logic [23:0] model_bits = '0;
   logic [23:0] cap = '0;
   int rise_k = 0, low_run = 0, high_run = 0, cs_hi_run = 1000, cs_falls = 0;
   logic prev_sclk = 1'b0, prev_cs = 1'b1, prev_mosi = 1'b0;
   bit r4_bad = 0, r10_bad = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!cs_n && prev_cs) begin
            cs_falls++;
            chk(cs_hi_run >= 2*H, "R9 gap", cs_hi_run, 2*H);
            rise_k = 0; cap = '0; low_run = 0; high_run = 0;
            r4_bad = 0; r10_bad = 0;
         end
         if (cs_n) cs_hi_run++; else cs_hi_run = 0;
         if (!cs_n && sclk && !prev_sclk) begin
            cap = {cap[22:0], mosi};
            rise_k++;
            if (low_run != H) r10_bad = 1;
            low_run = 0;
         end
         if (!cs_n && !prev_cs && !sclk && prev_sclk) begin
            if (high_run != H) r10_bad = 1;
            high_run = 0;
         end
         if (!cs_n && !prev_cs && sclk && prev_sclk && mosi != prev_mosi) r4_bad = 1;
         if (!cs_n) begin
            if (sclk) high_run++; else low_run++;
            miso = (rise_k < 24) ? model_bits[23 - rise_k] : 1'b0;
         end
         prev_sclk = sclk; prev_cs = cs_n; prev_mosi = mosi;
      end
   end

   task automatic do_frame(input bit ih_v, input bit se_v, input bit od_v, input bit mf_v,
                           input logic [11:0] res, input logic [10:0] junk,
                           input bit poke_busy, input bit poke_gap);
      int n;
      int falls_now;
      @(negedge clk);
      ih = ih_v; se = se_v; od = od_v; mf = mf_v;
      model_bits = {junk, 1'b0, res};
      n = 0;
      while (busy && n < 1000) begin @(negedge clk); n++; end
      @(negedge clk); @(negedge clk);
      chk(sclk == ih_v, "R5 idle level", sclk, ih_v);
      chk(cs_n == 1'b1, "R1 idle cs", cs_n, 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R8 busy after start", busy, 1);
      chk(cs_n == 1'b0, "R1 cs low", cs_n, 0);
      if (poke_busy) begin
         repeat (5*H) @(negedge clk);
         se = ~se_v; od = ~od_v; mf = ~mf_v; ih = ~ih_v;
         start = 1'b1;
         repeat (3) @(negedge clk);
         start = 1'b0;
      end
      n = 0;
      while (!done && n < 2000) begin @(negedge clk); n++; end
      chk(done == 1'b1, "R7 done arrives", done, 1);
      chk(result == res, "R6 result", result, res);
      chk(cs_n == 1'b1, "R7 cs rises with done", cs_n, 1);
      chk(rise_k == 24, "R1 edge count", rise_k, 24);
      chk(cap[23:16] == 8'h01, "R2 start byte", cap[23:16], 8'h01);
      chk(cap[15:13] == {se_v, od_v, mf_v}, "R3 command bits", cap[15:13], {se_v, od_v, mf_v});
      chk(cap[12:0] == 13'd0, "R3 padding", cap[12:0], 0);
      chk(!r4_bad, "R4 mosi stable high", r4_bad, 0);
      chk(!r10_bad, "R10 half period", r10_bad, 0);
      chk(sclk == ih_v, "R5 end level", sclk, ih_v);
      falls_now = cs_falls;
      if (poke_gap) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(!done, "R7 single cycle", done, 0);
      chk(result == res, "R7 hold", result, res);
      if (poke_gap) begin
         repeat (2*H + 3) @(negedge clk);
         chk(cs_falls == falls_now, "R8 start in gap ignored", cs_falls, falls_now);
         chk(cs_n == 1'b1 && !busy, "R8 idle after gap", {cs_n, busy}, 2);
      end
   endtask

   initial begin
      int seed_v;
      seed_v = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      chk(cs_n == 1'b1, "R11 cs", cs_n, 1);
      chk(sclk == 1'b0, "R11 sclk", sclk, 0);
      chk(mosi == 1'b0, "R11 mosi", mosi, 0);
      chk(!busy && !done, "R11 busy/done", {busy, done}, 0);
      chk(result == 12'd0, "R11 result", result, 0);
      rst_n = 1'b1;
      ih = 1'b1;
      repeat (2) @(negedge clk);
      chk(sclk == 1'b1, "R5 idle follows high", sclk, 1);
      ih = 1'b0;
      repeat (2) @(negedge clk);
      chk(sclk == 1'b0, "R5 idle follows low", sclk, 0);
      // directed corners
      do_frame(1'b0, 1'b1, 1'b0, 1'b1, 12'hFFF, 11'h000, 0, 0);
      do_frame(1'b1, 1'b0, 1'b1, 1'b0, 12'h000, 11'h7FF, 0, 0);
      do_frame(1'b0, 1'b1, 1'b1, 1'b1, 12'h800, 11'h555, 1, 1);
      do_frame(1'b1, 1'b0, 1'b0, 1'b0, 12'h001, 11'h2AA, 1, 1);
      // random frames
      for (int i = 0; i < 24; i++) begin
         logic [11:0] r;
         logic [10:0] j;
         logic [5:0]  f;
         r = 12'($urandom);
         j = 11'($urandom);
         f = 6'($urandom);
         do_frame(f[0], f[1], f[2], f[3], r, j, f[4], f[5]);
      end
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule